// File: doc/BRIEF.md
# Periodic Interrupt Divider and Flag Register

This block turns a 32.768 kHz time-base strobe into a selectable periodic event. A 4-bit rate code picks a power-of-two division of the time base, or switches the periodic event off. The same divider can drive a square-wave pin. Three interrupt sources are gathered in one flag byte: the periodic event, an alarm pulse and an update-ended pulse. Each source has its own enable. A summary bit and an active-high interrupt request are raised while any enabled flag is pending.

The time base arrives as `base_tick`, a one-cycle strobe in the `clk` domain. Software reads the flag byte from `flag_q`. It marks the read by pulsing `flag_rd` for one cycle. That read returns the current flags and clears all of them at the clock edge that ends the cycle. The alarm comparison and the time counting stay outside the block. They only deliver their pulses here.

Top module: `periodic_irq_unit`

## Requirements
- R1: For rate code n from 1 to 15, the periodic flag sets once every 2^(n-1) base ticks. Code 1 sets it on every tick (32768 Hz), code 2 every 2 ticks (16384 Hz), and so on down to code 15, every 16384 ticks (2 Hz).
- R2: Rate code 0 never sets the periodic flag.
- R3: The layout of `flag_q` is fixed. Bit 6 is the periodic flag, bit 5 the alarm flag and bit 4 the update-ended flag. Bits 3:0 always read 0.
- R4: Bit 7 of `flag_q` and `irq_o` are 1 exactly when some flag is set together with its enable. The enables are `en_periodic`, `en_alarm` and `en_update`.
- R5: During a cycle with `flag_rd` high, `flag_q` shows the flags held before the read. All flags are 0 after that clock edge.
- R6: A flag sets on its source event whether or not that source is enabled.
- R7: An event in the same cycle as a flag read leaves its flag set after the read.
- R8: With `en_square` high and code n from 2 to 15, `sqw_o` toggles every 2^(n-2) base ticks. With code 1 it toggles on every tick.
- R9: `sqw_o` is held low while `en_square` is low or the rate code is 0.
- R10: After reset, `flag_q` is 0 and both `irq_o` and `sqw_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_tick | input | 1 | One-cycle strobe at the 32.768 kHz time-base rate |
| rate_sel | input | 4 | Periodic rate code, 0 turns the periodic event off |
| en_periodic | input | 1 | Periodic interrupt enable |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_update | input | 1 | Update-ended interrupt enable |
| en_square | input | 1 | Square-wave output enable |
| alarm_evt | input | 1 | Alarm match pulse |
| update_evt | input | 1 | Update-ended pulse |
| flag_rd | input | 1 | Flag byte read strobe, clears the flags |
| flag_q | output | 8 | Flag byte: summary, periodic, alarm, update flags |
| irq_o | output | 1 | Interrupt request, active high |
| sqw_o | output | 1 | Square-wave output |

## Verification
Some rules are checked by assertions on every cycle:
- A read with no coinciding event leaves the alarm flag clear.
- An alarm pulse always sets its flag on the next cycle.
- The interrupt request stays low while every enable is off.
- Code 0 never raises the periodic flag.
- The square wave drops low once disabled.

The bench scenarios show the rest. They measure the exact spacing in ticks between periodic flags and between square-wave toggles for several codes. They also show that a read returns the flags held before it. Finally, they check an event landing on the read cycle and the moment the request rises when an enable is set over an already-pending flag.

// File: rtl/periodic_irq_unit.sv
`timescale 1ns/1ps
module periodic_irq_unit #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             en_periodic,
  input  logic             en_alarm,
  input  logic             en_update,
  input  logic             en_square,
  input  logic             alarm_evt,
  input  logic             update_evt,
  input  logic             flag_rd,
  output logic [7:0]       flag_q,
  output logic             irq_o,
  output logic             sqw_o
);
  localparam int DIV_W = (1 << SEL_W) - 2;

  logic [DIV_W-1:0] div_q, per_mask, sq_mask;
  logic per_f, alm_f, upd_f, sq_q;
  logic rate_on, per_evt, sq_edge, any_pend;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      per_mask[i] = (i < int'(rate_sel) - 1);
      sq_mask[i]  = (i < int'(rate_sel) - 2);
    end
  end

  assign rate_on = (rate_sel != '0);
  assign per_evt = base_tick && rate_on && ((div_q & per_mask) == per_mask);
  assign sq_edge = base_tick && rate_on && (((div_q + 1'b1) & sq_mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         div_q <= '0;
    else if (base_tick) div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      sq_q <= 1'b0;
    else if (!en_square || !rate_on) sq_q <= 1'b0;
    else if (sq_edge)                sq_q <= ~sq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_f <= 1'b0;
      alm_f <= 1'b0;
      upd_f <= 1'b0;
    end else begin
      per_f <= (per_f && !flag_rd) || per_evt;
      alm_f <= (alm_f && !flag_rd) || alarm_evt;
      upd_f <= (upd_f && !flag_rd) || update_evt;
    end
  end

  assign any_pend = (per_f && en_periodic) || (alm_f && en_alarm) || (upd_f && en_update);
  assign flag_q   = {any_pend, per_f, alm_f, upd_f, 4'b0000};
  assign irq_o    = any_pend;
  assign sqw_o    = sq_q;

  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !alarm_evt) |=> !flag_q[5]);
  // R6
  alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> flag_q[5]);
  // R4
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_periodic && !en_alarm && !en_update) |-> !irq_o);
  // R2
  rate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rate_sel == '0) && !flag_q[6]) |=> !flag_q[6]);
  // R9
  sq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_square |=> !sqw_o);
endmodule

// File: tb/periodic_irq_unit_bench.sv
`timescale 1ns/1ps
module periodic_irq_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0, base_tick = 1'b0;
  logic [3:0] rate_sel = '0;
  logic en_periodic = 0, en_alarm = 0, en_update = 0, en_square = 0;
  logic alarm_evt = 0, update_evt = 0, flag_rd = 0;
  logic [7:0] flag_q;
  logic irq_o, sqw_o;
  int n_run = 0, n_fail = 0;
  int tick_cnt = 0;

  periodic_irq_unit u_periodic_irq_unit (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .rate_sel(rate_sel),
    .en_periodic(en_periodic), .en_alarm(en_alarm), .en_update(en_update),
    .en_square(en_square), .alarm_evt(alarm_evt), .update_evt(update_evt),
    .flag_rd(flag_rd), .flag_q(flag_q), .irq_o(irq_o), .sqw_o(sqw_o)
  );

  always #2.5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    if (rst_n) base_tick = ~base_tick;
  end

  always @(posedge clk) if (rst_n && base_tick) tick_cnt <= tick_cnt + 1;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_read();
    flag_rd = 1'b1;
    @(negedge clk);
    flag_rd = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 flags", flag_q, 0);
    check("R10 irq", irq_o, 0);
    check("R10 sqw", sqw_o, 0);
  endtask

  task automatic t_period(input int code);
    int t0;
    rate_sel = 4'(code);
    en_periodic = 1'b1;
    do_read();
    while (!irq_o) @(negedge clk);
    t0 = tick_cnt;
    check("R1 flag bit6", flag_q[6], 1);
    do_read();
    while (!irq_o) @(negedge clk);
    check($sformatf("R1 period code %0d", code), tick_cnt - t0, 1 << (code - 1));
    do_read();
  endtask

  task automatic t_rate_off();
    rate_sel = 4'd0;
    en_periodic = 1'b1;
    en_square = 1'b1;
    repeat (4) @(negedge clk);
    do_read();
    repeat (200) @(negedge clk);
    check("R2 periodic flag at code 0", flag_q[6], 0);
    check("R9 sqw at code 0", sqw_o, 0);
    en_square = 1'b0;
    en_periodic = 1'b0;
  endtask

  task automatic t_alarm_masked();
    en_alarm = 1'b0;
    alarm_evt = 1'b1;
    @(negedge clk);
    alarm_evt = 1'b0;
    check("R6 alarm flag without enable", flag_q[5], 1);
    check("R3 low nibble", flag_q[3:0], 0);
    check("R4 summary masked", flag_q[7], 0);
    check("R4 irq masked", irq_o, 0);
    en_alarm = 1'b1;
    #0.1;
    check("R4 irq after enable", irq_o, 1);
    check("R4 summary after enable", flag_q[7], 1);
    flag_rd = 1'b1;
    #0.1;
    check("R5 value during read", flag_q, 8'hA0);
    @(negedge clk);
    flag_rd = 1'b0;
    check("R5 cleared after read", flag_q, 0);
    check("R5 irq cleared", irq_o, 0);
    en_alarm = 1'b0;
  endtask

  task automatic t_update_collide();
    en_update = 1'b1;
    update_evt = 1'b1;
    @(negedge clk);
    update_evt = 1'b0;
    check("R3 update flag bit4", flag_q, 8'h90);
    check("R4 irq update", irq_o, 1);
    flag_rd = 1'b1;
    update_evt = 1'b1;
    @(negedge clk);
    flag_rd = 1'b0;
    update_evt = 1'b0;
    check("R7 event on read cycle kept", flag_q[4], 1);
    do_read();
    check("R5 update cleared", flag_q[4], 0);
    en_update = 1'b0;
  endtask

  task automatic t_square(input int code);
    int t0;
    logic prev;
    rate_sel = 4'(code);
    en_square = 1'b1;
    prev = sqw_o;
    while (sqw_o == prev) @(negedge clk);
    prev = sqw_o;
    t0 = tick_cnt;
    while (sqw_o == prev) @(negedge clk);
    check($sformatf("R8 toggle spacing code %0d", code), tick_cnt - t0,
          (code == 1) ? 1 : (1 << (code - 2)));
    en_square = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9 sqw low when disabled", sqw_o, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alarm_masked();
    t_update_collide();
    t_rate_off();
    t_period(1);
    t_period(2);
    t_period(3);
    t_period(6);
    t_period(15);
    en_periodic = 1'b0;
    do_read();
    t_square(1);
    t_square(2);
    t_square(5);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule